// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a bus-slave SPI master that sends and receives one word of 1 to 32 bits for each start command. Software writes the outgoing word into a four-entry transmit queue. It then writes the control register with the length, mode, chip-select choice and start bit, and polls a ready flag. Finally it pops the received word from a four-entry receive queue. The serial engine drives SCK, MOSI and four chip-select lines and samples MISO. SCK runs at the system clock divided by twice the `CLK_HALF` parameter.

The control register holds the following fields:
- SPI mode (clock polarity and clock phase).
- Bit order.
- Transmit and receive enables.
- A chip-select index, with a per-line idle polarity.
- A software override that drives the selected chip select directly.

Queue errors are recorded as sticky flags, which software clears by writing ones. Writing back a value that was just read from the status register clears every flag it reported.

Top module: `spi_master`

## Requirements
- R1: After reset, the control register (0x000) reads 0, the transfer status (0x010) reads 0, and the queue status (0x014) reads 0x5. In that value, bit 2 means transmit queue empty and bit 0 means receive queue empty. All four chip-select outputs are high and SCK is low.
- R2: Writing 0x000 with bit 31 (start) and bit 30 (master) both set transfers `len+1` bits, where `len` is bits 4:0. The most significant valid bit goes first unless R4 applies. Bit 30 of 0x010 (ready) becomes 1 after the last SCK edge. A start written without bit 30 does nothing.
- R3: Bits 29:28 of the control register hold {CPOL, CPHA}. SCK idles at CPOL. The data is sampled on the leading SCK edge when CPHA is 0, and on the trailing edge when CPHA is 1. MOSI is stable on every sampling edge.
- R4: When bit 16 is set, the word goes out least significant bit first.
- R5: When bit 12 (receive enable) is set, the sampled MISO bits are pushed into the receive queue as a right-aligned word, read at 0x188. When bit 12 is clear, nothing is pushed.
- R6: When bit 11 (transmit enable) is set, the start pops the word from the transmit queue, which is written at 0x108. When bit 11 is clear, MOSI stays low and the transmit queue is left untouched.
- R7: Bits 27:26 select chip-select line `i`. Bit 22+`i` sets that line's polarity: 0 means it idles high and is active low, and 1 means the reverse. In hardware mode the selected line is active only while a transfer runs. All other lines stay idle.
- R8: When bit 21 is set, the selected chip-select line follows bit 20 directly.
- R9: Writing 0x108 while four words are queued drops the word and sets bits 7 and 8 of 0x014. Bit 3 reads 1 while the transmit queue is full.
- R10: Reading 0x188 while the receive queue is empty sets bits 4 and 8 of 0x014.
- R11: A start with transmit enabled and an empty transmit queue sends zeros and sets bits 6 and 8. A completion with receive enabled and a full receive queue drops the word and sets bits 5 and 8. Bit 1 reads 1 while the receive queue is full.
- R12: Writing a 1 to bit 30 of 0x010, or to any of bits 8:4 of 0x014, clears that flag. Writing a 0 leaves the flag unchanged. Writing back a value just read from 0x014 clears every flag that value reported.
- R13: Bit 31 of 0x000 reads 1 while a transfer is in progress. A start written while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe; pops the receive queue at 0x188 |
| busAddr | input | 10 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 4 | Chip-select lines |

## Verification
Read data is combinational, so a register value is due in the same cycle as its address. Any effect of a write or a pop shows one clock edge later. Each wire bit appears half an SCK period before its sampling edge. Ready rises one cycle after the final edge, that is, 2·(len+1)·CLK_HALF cycles after the start edge plus one. The bench drives every input at the falling clock edge and reads results there or 1 ns later. It polls ready rather than assuming a count. Its wire monitor reconstructs each transmitted bit from the MOSI value held before the sampling SCK transition, so a bit is never read in the same instant that it changes.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int CS_N = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 10'h000;
  localparam logic [ADDR_W-1:0] A_AUX    = 10'h004;
  localparam logic [ADDR_W-1:0] A_XSTAT  = 10'h010;
  localparam logic [ADDR_W-1:0] A_QSTAT  = 10'h014;
  localparam logic [ADDR_W-1:0] A_TXPORT = 10'h108;
  localparam logic [ADDR_W-1:0] A_RXPORT = 10'h188;

  typedef struct packed {
    logic              start;
    logic [DATA_W-1:0] word;
    logic [4:0]        lenM1;
    logic              cpol;
    logic              cpha;
    logic              lsbFirst;
    logic              idlePol;
  } engCmd_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wPtr, rPtr;
  logic         doPush, doPop;

  assign empty  = (wPtr == rPtr);
  assign full   = (wPtr[PW] != rPtr[PW]) && (wPtr[PW-1:0] == rPtr[PW-1:0]);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rPtr[PW-1:0]];

  always_ff @(posedge clk) begin
    if (doPush) mem[wPtr[PW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wPtr <= '0;
      rPtr <= '0;
    end else begin
      if (doPush) wPtr <= wPtr + 1'b1;
      if (doPop)  rPtr <= rPtr + 1'b1;
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_master_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output engCmd_t           engCmd,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic [DATA_W-1:0] engRxWord,
  output logic [CS_N-1:0]   csOut
);
  logic [DATA_W-2:0] cfg;
  logic [DATA_W-1:0] aux;
  logic ready, errSum, txOvf, txUnr, rxOvf, rxUnr;
  logic [DATA_W-1:0] txHead, rxHead, clrMask;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic goReq, txPush, txPop, rxPush, rxPop;
  logic txOvfSet, txUnrSet, rxOvfSet, rxUnrSet;

  assign goReq  = busWr && busAddr == A_CTRL && busWdata[31] && busWdata[30] && !engBusy;
  assign txPush = busWr && busAddr == A_TXPORT;
  assign txPop  = goReq && busWdata[11] && !txEmpty;
  assign rxPush = engDone && cfg[12];
  assign rxPop  = busRd && busAddr == A_RXPORT;

  assign txOvfSet = txPush && txFull;
  assign txUnrSet = goReq && busWdata[11] && txEmpty;
  assign rxOvfSet = rxPush && rxFull;
  assign rxUnrSet = rxPop && rxEmpty;
  assign clrMask  = (busWr && busAddr == A_QSTAT) ? busWdata : '0;

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rst(rst), .push(txPush), .din(busWdata), .pop(txPop),
    .dout(txHead), .full(txFull), .empty(txEmpty));

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rst(rst), .push(rxPush), .din(engRxWord), .pop(rxPop),
    .dout(rxHead), .full(rxFull), .empty(rxEmpty));

  always_comb begin
    engCmd.start    = goReq;
    engCmd.word     = txPop ? txHead : '0;
    engCmd.lenM1    = busWdata[4:0];
    engCmd.cpol     = busWdata[29];
    engCmd.cpha     = busWdata[28];
    engCmd.lsbFirst = busWdata[16];
    engCmd.idlePol  = cfg[29];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      aux    <= '0;
      ready  <= 1'b0;
      errSum <= 1'b0;
      txOvf  <= 1'b0;
      txUnr  <= 1'b0;
      rxOvf  <= 1'b0;
      rxUnr  <= 1'b0;
    end else begin
      if (busWr && busAddr == A_CTRL) cfg <= busWdata[DATA_W-2:0];
      if (busWr && busAddr == A_AUX)  aux <= busWdata;
      if (engDone) ready <= 1'b1;
      else if (busWr && busAddr == A_XSTAT && busWdata[30]) ready <= 1'b0;
      txOvf  <= txOvfSet | (txOvf & ~clrMask[7]);
      txUnr  <= txUnrSet | (txUnr & ~clrMask[6]);
      rxOvf  <= rxOvfSet | (rxOvf & ~clrMask[5]);
      rxUnr  <= rxUnrSet | (rxUnr & ~clrMask[4]);
      errSum <= (txOvfSet | txUnrSet | rxOvfSet | rxUnrSet) | (errSum & ~clrMask[8]);
    end
  end

  always_comb begin
    unique case (busAddr)
      A_CTRL:   busRdata = {engBusy, cfg};
      A_AUX:    busRdata = aux;
      A_XSTAT:  busRdata = {1'b0, ready, 30'b0};
      A_QSTAT:  busRdata = {23'b0, errSum, txOvf, txUnr, rxOvf, rxUnr,
                            txFull, txEmpty, rxFull, rxEmpty};
      A_RXPORT: busRdata = rxHead;
      default:  busRdata = '0;
    endcase
  end

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    logic selHit, idleLvl;
    assign selHit  = (cfg[27:26] == 2'(i));
    assign idleLvl = ~cfg[22+i];
    assign csOut[i] = !selHit ? idleLvl :
                      cfg[21] ? cfg[20] :
                      (engBusy ? ~idleLvl : idleLvl);
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_master_pkg::*;
#(
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  engCmd_t           engCmd,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxWord
);
  localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [DW-1:0]     divCnt;
  logic [6:0]        edgeCnt, edgeNext, edgeTotal;
  logic [DATA_W-1:0] txSh, rxSh, rxNext;
  logic [4:0]        lenR;
  logic              sckR, cphaR, lsbR;
  logic              tick, sampleNow, shiftNow, lastEdge;

  function automatic logic [DATA_W-1:0] rev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  assign tick      = busy && (divCnt == DW'(CLK_HALF - 1));
  assign edgeNext  = edgeCnt + 7'd1;
  assign edgeTotal = 7'(({2'b0, lenR} + 7'd1) << 1);
  assign sampleNow = tick && (edgeNext[0] ^ cphaR);
  assign shiftNow  = tick && !(edgeNext[0] ^ cphaR) && (edgeNext != 7'd1);
  assign lastEdge  = tick && (edgeNext == edgeTotal);
  assign rxNext    = sampleNow ? {rxSh[DATA_W-2:0], miso} : rxSh;

  assign sck  = busy ? sckR : engCmd.idlePol;
  assign mosi = busy && txSh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sckR    <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      txSh    <= '0;
      rxSh    <= '0;
      rxWord  <= '0;
      lenR    <= '0;
      cphaR   <= 1'b0;
      lsbR    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (engCmd.start) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        edgeCnt <= '0;
        sckR    <= engCmd.cpol;
        txSh    <= engCmd.lsbFirst ? rev(engCmd.word)
                                   : engCmd.word << (5'd31 - engCmd.lenM1);
        rxSh    <= '0;
        lenR    <= engCmd.lenM1;
        cphaR   <= engCmd.cpha;
        lsbR    <= engCmd.lsbFirst;
      end else if (busy) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          sckR    <= ~sckR;
          edgeCnt <= edgeNext;
          rxSh    <= rxNext;
          if (shiftNow) txSh <= txSh << 1;
          if (lastEdge) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            rxWord <= lsbR ? (rev(rxNext) >> (5'd31 - lenR)) : rxNext;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_master.sv
module spi_master
  import spi_master_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   csOut
);
  engCmd_t           engCmd;
  logic              engBusy, engDone;
  logic [DATA_W-1:0] engRxWord;

  spi_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .engCmd(engCmd),
    .engBusy(engBusy), .engDone(engDone), .engRxWord(engRxWord), .csOut(csOut));

  spi_engine #(.CLK_HALF(CLK_HALF)) u_engine (
    .clk(clk), .rst(rst), .engCmd(engCmd), .miso(miso), .sck(sck), .mosi(mosi),
    .busy(engBusy), .done(engDone), .rxWord(engRxWord));
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       busWr,
  input logic       engBusy,
  input logic       engDone,
  input logic       engStart,
  input logic       sck,
  input logic [3:0] csOut
);
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    engDone |-> (!engBusy && $past(engBusy))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    engDone |=> !engDone); // R2
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    engStart |-> !engBusy); // R13
  AST_SCK_STILL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!engBusy && !$past(engBusy) && !$past(busWr)) |-> $stable(sck)); // R3
  AST_CS_STILL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!engBusy && !$past(engBusy) && !$past(busWr)) |-> $stable(csOut)); // R7
endmodule

bind spi_master spi_master_chk u_chk (
  .clk(clk), .rst(rst), .busWr(busWr), .engBusy(engBusy), .engDone(engDone),
  .engStart(engCmd.start), .sck(sck), .csOut(csOut));

// File: tb/tb_spi_master.sv
`timescale 1ns/1ps
module tb_spi_master;
  localparam logic [9:0] A_CTRL = 10'h000, A_XSTAT = 10'h010, A_QSTAT = 10'h014,
                         A_TX = 10'h108, A_RX = 10'h188;

  logic clk = 1'b0, rst = 1'b1, busWr = 1'b0, busRd = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic sck, mosi, miso;
  logic [3:0] csOut;
  int total = 0, bad = 0;

  typedef struct { logic [31:0] seq; int len; bit rise; } wItem_t;
  wItem_t wq[$];

  always #2 clk = ~clk;
  assign miso = mosi;

  spi_master dut (.clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi), .miso(miso),
    .csOut(csOut));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  function automatic logic [31:0] mkCfg(input int mode, input int sel, input int len,
      input int txEn, input int rxEn, input int lsb, input int pol, input int sw, input int swVal);
    return 32'h4000_0000 | 32'(mode << 28) | 32'(sel << 26) | 32'(pol << 22) |
           32'(sw << 21) | 32'(swVal << 20) | 32'(lsb << 16) | 32'(rxEn << 12) |
           32'(txEn << 11) | 32'(len);
  endfunction

  function automatic logic [31:0] wireOf(input logic [31:0] w, input int len, input bit lsb);
    logic [31:0] r = '0;
    if (!lsb) return (len == 31) ? w : (w & ((32'd1 << (len + 1)) - 1));
    for (int i = 0; i <= len; i++) r = {r[30:0], w[i]};
    return r;
  endfunction

  // driver: pushes the expected wire sequence, starts the transfer, waits for ready
  task automatic xfer(input logic [31:0] cfg, input logic [31:0] wireSeq,
                      input bit checkMid, input logic [3:0] midCs);
    wItem_t it;
    logic [31:0] d;
    int tries = 0;
    busWrite(A_CTRL, cfg);
    @(negedge clk);
    it.seq = wireSeq; it.len = int'(cfg[4:0]);
    it.rise = (cfg[29] == cfg[28]);
    wq.push_back(it);
    busWrite(A_CTRL, cfg | 32'h8000_0000);
    if (checkMid) begin
      busRead(A_CTRL, d);
      check("R13 busy readback", {31'b0, d[31]}, 32'd1);
      check("R7 cs during transfer", {28'b0, csOut}, {28'b0, midCs});
    end
    d = '0;
    while (!d[30] && tries < 600) begin busRead(A_XSTAT, d); tries++; end
    check("R2 ready set", {31'b0, d[30]}, 32'd1);
    busWrite(A_XSTAT, 32'h4000_0000);
    busRead(A_XSTAT, d);
    check("R12 ready cleared", d, 32'd0);
  endtask

  // monitor: rebuilds wire bits from MOSI held before each sampling SCK transition
  initial begin
    logic prevSck = 1'b0, prevMosi = 1'b0;
    logic [31:0] acc = '0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (wq.size() > 0 && sck !== prevSck && sck == wq[0].rise) begin
        acc = {acc[30:0], prevMosi};
        cnt++;
        if (cnt == wq[0].len + 1) begin
          check("R2/R3/R4 wire bits", acc, wq[0].seq);
          void'(wq.pop_front());
          cnt = 0; acc = '0;
        end
      end
      prevSck = sck; prevMosi = mosi;
    end
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d, c;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    busRead(A_CTRL, d);  check("R1 ctrl reset", d, 32'h0);
    busRead(A_XSTAT, d); check("R1 xstat reset", d, 32'h0);
    busRead(A_QSTAT, d); check("R1 qstat reset", d, 32'h5);
    check("R1 cs reset", {28'b0, csOut}, 32'hF);
    check("R1 sck reset", {31'b0, sck}, 32'h0);

    // R2 start without master bit does nothing
    busWrite(A_CTRL, 32'h8000_081F);
    repeat (20) @(negedge clk);
    busRead(A_XSTAT, d); check("R2 no master no ready", d, 32'h0);
    busRead(A_QSTAT, d); check("R2 no master no underrun", d, 32'h5);
    check("R2 no master sck idle", {31'b0, sck}, 32'h0);

    // mode 0, 32 bits
    busWrite(A_TX, 32'hA5C3_0F96);
    xfer(mkCfg(0, 0, 31, 1, 1, 0, 0, 0, 0), wireOf(32'hA5C3_0F96, 31, 0), 1, 4'b1110);
    busRead(A_RX, d); check("R5 rx mode0", d, 32'hA5C3_0F96);
    // mode 1, 8 bits, line 2
    busWrite(A_TX, 32'h5A);
    xfer(mkCfg(1, 2, 7, 1, 1, 0, 0, 0, 0), wireOf(32'h5A, 7, 0), 1, 4'b1011);
    busRead(A_RX, d); check("R5 rx mode1", d, 32'h5A);
    // mode 2, idle high
    c = mkCfg(2, 3, 15, 1, 1, 0, 0, 0, 0);
    busWrite(A_CTRL, c);
    @(negedge clk);
    check("R3 sck idles at cpol", {31'b0, sck}, 32'h1);
    busWrite(A_TX, 32'h1234);
    xfer(c, wireOf(32'h1234, 15, 0), 1, 4'b0111);
    busRead(A_RX, d); check("R5 rx mode2", d, 32'h1234);
    // mode 3, single bit
    busWrite(A_TX, 32'h1);
    xfer(mkCfg(3, 0, 0, 1, 1, 0, 0, 0, 0), 32'h1, 0, 4'h0);
    busRead(A_RX, d); check("R5 rx mode3 one bit", d, 32'h1);
    // R4 lsb first
    busWrite(A_TX, 32'hABC);
    xfer(mkCfg(0, 0, 11, 1, 1, 1, 0, 0, 0), wireOf(32'hABC, 11, 1), 0, 4'h0);
    busRead(A_RX, d); check("R4 rx lsb first", d, 32'hABC);

    // R6 transmit disabled leaves queue alone; R5 receive disabled pushes nothing
    busWrite(A_TX, 32'hDEAD);
    xfer(mkCfg(0, 0, 15, 0, 0, 0, 0, 0, 0), 32'h0, 0, 4'h0);
    busRead(A_QSTAT, d); check("R6 tx queue untouched / R5 no push", d, 32'h1);
    xfer(mkCfg(0, 0, 15, 1, 1, 0, 0, 0, 0), 32'hDEAD, 0, 4'h0);
    busRead(A_RX, d); check("R6 held word sent later", d, 32'hDEAD);

    // R8 software chip select
    busWrite(A_CTRL, mkCfg(0, 1, 7, 1, 1, 0, 0, 1, 0));
    @(negedge clk); check("R8 sw cs low", {28'b0, csOut}, 32'hD);
    busWrite(A_CTRL, mkCfg(0, 1, 7, 1, 1, 0, 0, 1, 1));
    @(negedge clk); check("R8 sw cs high", {28'b0, csOut}, 32'hF);

    // R7 polarity of line 1
    c = mkCfg(0, 1, 7, 1, 1, 0, 4'b0010, 0, 0);
    busWrite(A_CTRL, c);
    @(negedge clk); check("R7 inverted idle", {28'b0, csOut}, 32'hD);
    busWrite(A_TX, 32'h3C);
    xfer(c, 32'h3C, 1, 4'b1111);
    busRead(A_RX, d); check("R7 rx with inverted cs", d, 32'h3C);

    // R9 transmit overflow
    for (int i = 1; i <= 5; i++) busWrite(A_TX, 32'(i));
    busRead(A_QSTAT, d); check("R9 tx overflow flags", d, 32'h189);
    busWrite(A_QSTAT, 32'h180);
    busRead(A_QSTAT, d); check("R12 clear ovf", d, 32'h9);

    // R11 four words then underrun plus receive overflow
    for (int i = 1; i <= 4; i++) xfer(mkCfg(0, 0, 7, 1, 1, 0, 0, 0, 0), 32'(i), 0, 4'h0);
    busRead(A_QSTAT, d); check("R11 rx full", d, 32'h6);
    xfer(mkCfg(0, 0, 7, 1, 1, 0, 0, 0, 0), 32'h0, 0, 4'h0);
    busRead(A_QSTAT, d); check("R11 underrun and rx overflow", d, 32'h166);
    for (int i = 1; i <= 4; i++) begin
      busRead(A_RX, d); check("R11 rx order, extra dropped", d, 32'(i));
    end
    busRead(A_QSTAT, d); check("R11 status after drain", d, 32'h165);
    busWrite(A_QSTAT, d);
    busRead(A_QSTAT, d); check("R12 write-back clears", d, 32'h5);

    // R10 receive underrun
    busRead(A_RX, d);
    busRead(A_QSTAT, d); check("R10 rx underrun", d, 32'h115);
    busWrite(A_QSTAT, 32'h0);
    busRead(A_QSTAT, d); check("R12 zero write keeps", d, 32'h115);
    busWrite(A_QSTAT, 32'h110);
    busRead(A_QSTAT, d); check("R12 selective clear", d, 32'h5);

    repeat (10) @(negedge clk);
    check("R2 wire queue drained", 32'(wq.size()), 32'h0);
    finishRun();
  end
endmodule